// File: doc/BRIEF.md
# Falling-Edge Request Front End for a Single DMA Channel

This block starts and sequences transfers for one DMA channel driven by an external active-low request line. The line is synchronized to the bus clock and sampled on every rising edge once the channel is enabled. A low level seen while acceptance is armed is held as a pending request. The block then asserts its bus request and waits a fixed arbitration time. It runs one read cycle from the source address and one write cycle to the destination address, then releases the bus.

Acceptance is disarmed when a request is taken. It is armed again only if the line has been seen high. This is checked at the end of the write cycle. If the line was not yet high by then, acceptance re-arms on the first high level sampled while idle. A line held low therefore produces exactly one transfer.

A transfer count, source base and destination base are loaded before the channel is enabled. Both addresses increment after each transfer. When the count reaches zero the block raises `done` and clears its enable.

Both bus cycles use a valid/ready handshake. The read cycle holds `rd_stb` and `src_addr` until `rd_rdy` is sampled high, and `rd_data` is captured on that edge. The write cycle holds `wr_stb`, `dst_addr` and `wr_data` until `wr_rdy` is sampled high. A low ready stalls the sequence with no limit on the stall length.

Top module: `dreq_dma_front`

## Requirements
- R1: After reset `bus_req`, `rd_stb`, `wr_stb` and `done` are low.
- R2: While the channel enable is off, a low level on `req_n` starts no transfer and `bus_req` stays low.
- R3: With the channel enabled, armed and idle, `rd_stb` first goes high on the WAIT_CYC+4th rising edge after `req_n` falls. The delay is made of 2 synchronizer stages, 1 capture, 1 activation and WAIT_CYC wait cycles.
- R4: `bus_req` rises on the 4th rising edge after `req_n` falls. It stays high through the read and write cycles and is low in the cycle after the write handshake.
- R5: Each transfer is exactly one read followed by one write. `wr_data` equals the `rd_data` value captured at the read handshake. `rd_stb` and `wr_stb` are never high together.
- R6: A strobe without its ready stays high, with its address (and `wr_data` for writes) unchanged, until ready is sampled high.
- R7: The first transfer after `cnt_load` uses `src_base` and `dst_base`. Each completed transfer increments both addresses by one.
- R8: If `req_n` is still low when the write cycle ends and no high level was seen during the transfer, no new transfer starts until a high level has been sampled. A following low level then starts one.
- R9: If a high level on `req_n` was sampled during the transfer, acceptance is re-armed at write completion. A low level driven right after the bus is released then starts the next transfer with the R3 latency.
- R10: The write that brings the loaded count to zero sets `done` and turns the channel enable off. Further low levels on `req_n` start nothing. `done` clears on `cnt_load` or on an enable write of 1.
- R11: At least 3 cycles (WAIT_CYC, default 3, minimum 3) with `bus_req` high and no strobe come before every read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | External active-low transfer request, asynchronous |
| en_wr | input | 1 | Write strobe for the channel enable bit |
| en_wdata | input | 1 | Value written to the channel enable bit |
| cnt_load | input | 1 | Loads count, source base and destination base |
| cnt_val | input | CW | Number of transfers to run |
| src_base | input | AW | First source address |
| dst_base | input | AW | First destination address |
| bus_req | output | 1 | Bus held by the channel |
| rd_stb | output | 1 | Read cycle valid |
| rd_rdy | input | 1 | Read cycle ready; data accepted on this edge |
| src_addr | output | AW | Current source address |
| rd_data | input | DW | Data returned by the read |
| wr_stb | output | 1 | Write cycle valid |
| wr_rdy | input | 1 | Write cycle ready |
| dst_addr | output | AW | Current destination address |
| wr_data | output | DW | Data driven during the write |
| done | output | 1 | Loaded transfer count exhausted |

## Verification
The assertions are evaluated on every cycle for the bus-cycle rules. These are: a strobe implies a bus request, the read is followed directly by the write, the two strobes are exclusive, a stalled strobe holds its address and data, the minimum wait comes before each read, and `done` keeps the bus released. The request-qualification behaviour depends on the history of the external line and on exact edge counts, so only the directed scenarios can show it. That covers the latency from a falling line to the read strobe, the single transfer for a line held low, the re-arm after a high level seen mid-transfer, and the refusal of requests after the count runs out.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } xfer_st_t;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/dreq_arm.sv
// Enable bit, acceptance arming and the held pending request.
module dreq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,     // synchronized line, active low
  input  logic en_wr,
  input  logic en_wdata,
  input  logic idle,
  input  logic start,
  input  logic wr_done,
  input  logic last,
  output logic en_q,
  output logic pending
);
  logic armed, seen_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      armed     <= 1'b0;
      pending   <= 1'b0;
      seen_high <= 1'b0;
    end else begin
      if (start) begin
        pending   <= 1'b0;
        armed     <= 1'b0;
        seen_high <= 1'b0;
      end else if (wr_done) begin
        seen_high <= 1'b0;
        if (last) begin
          en_q  <= 1'b0;
          armed <= 1'b0;
        end else begin
          armed <= seen_high | req_s;
        end
      end else begin
        if (!idle && req_s) seen_high <= 1'b1;
        if (idle && en_q && !armed && req_s) armed <= 1'b1;
        if (en_q && armed && !req_s) pending <= 1'b1;
      end
      if (en_wr) begin
        en_q <= en_wdata;
        if (en_wdata && idle) armed <= 1'b1;
        if (!en_wdata) begin
          pending <= 1'b0;
          armed   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dreq_xfer.sv
// Arbitration wait, read cycle, write cycle, count and addresses.
module dreq_xfer
  import dreq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int WAIT_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pending,
  input  logic          en_set,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_val,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic          rd_rdy,
  input  logic [DW-1:0] rd_data,
  input  logic          wr_rdy,
  output logic          idle,
  output logic          start,
  output logic          wr_done,
  output logic          last,
  output logic          bus_req,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  localparam int WW = $clog2(WAIT_CYC + 1);

  xfer_st_t      st;
  logic [WW-1:0] wcnt;
  logic [CW-1:0] cnt;

  assign idle    = (st == ST_IDLE);
  assign start   = idle && pending;
  assign wr_done = (st == ST_WRITE) && wr_rdy;
  assign last    = (cnt == CW'(1));
  assign bus_req = !idle;
  assign rd_stb  = (st == ST_READ);
  assign wr_stb  = (st == ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wcnt     <= '0;
      cnt      <= '0;
      src_addr <= '0;
      dst_addr <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
    end else begin
      if (cnt_load) begin
        cnt      <= cnt_val;
        src_addr <= src_base;
        dst_addr <= dst_base;
        done     <= 1'b0;
      end
      if (en_set) done <= 1'b0;
      case (st)
        ST_IDLE: if (pending) begin
          st   <= ST_WAIT;
          wcnt <= '0;
        end
        ST_WAIT: begin
          if (wcnt == WW'(WAIT_CYC - 1)) st <= ST_READ;
          else                           wcnt <= wcnt + 1'b1;
        end
        ST_READ: if (rd_rdy) begin
          wr_data <= rd_data;
          st      <= ST_WRITE;
        end
        ST_WRITE: if (wr_rdy) begin
          st       <= ST_IDLE;
          cnt      <= cnt - 1'b1;
          src_addr <= src_addr + 1'b1;
          dst_addr <= dst_addr + 1'b1;
          if (last) done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dreq_dma_front.sv
module dreq_dma_front #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int WAIT_CYC = 3,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_n,
  input  logic          en_wr,
  input  logic          en_wdata,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_val,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  output logic          bus_req,
  output logic          rd_stb,
  input  logic          rd_rdy,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_stb,
  input  logic          wr_rdy,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  logic req_s, en_q, pending, idle, start, wr_done, last;

  dreq_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_s)
  );

  dreq_arm u_arm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .en_wr(en_wr), .en_wdata(en_wdata),
    .idle(idle), .start(start), .wr_done(wr_done), .last(last),
    .en_q(en_q), .pending(pending)
  );

  dreq_xfer #(.AW(AW), .DW(DW), .CW(CW), .WAIT_CYC(WAIT_CYC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .pending(pending), .en_set(en_wr && en_wdata),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .src_base(src_base), .dst_base(dst_base),
    .rd_rdy(rd_rdy), .rd_data(rd_data), .wr_rdy(wr_rdy),
    .idle(idle), .start(start), .wr_done(wr_done), .last(last),
    .bus_req(bus_req), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .src_addr(src_addr), .dst_addr(dst_addr), .wr_data(wr_data), .done(done)
  );
endmodule

// File: rtl/dreq_dma_front_chk.sv
module dreq_dma_front_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          rd_stb,
  input logic          rd_rdy,
  input logic [AW-1:0] src_addr,
  input logic          wr_stb,
  input logic          wr_rdy,
  input logic [AW-1:0] dst_addr,
  input logic [DW-1:0] wr_data,
  input logic          done
);
  logic [7:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              quiet_cnt <= '0;
    else if (!bus_req || rd_stb || wr_stb)   quiet_cnt <= '0;
    else if (quiet_cnt != 8'hFF)             quiet_cnt <= quiet_cnt + 1'b1;
  end

  a_r4_strobe_has_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> bus_req);
  a_r5_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_rdy) |=> wr_stb);
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_rdy) |=> (rd_stb && $stable(src_addr)));
  a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_rdy) |=> (wr_stb && $stable(dst_addr) && $stable(wr_data)));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);
  a_r11_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb) |-> (quiet_cnt >= 8'd3));
endmodule

bind dreq_dma_front dreq_dma_front_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .rd_stb(rd_stb), .rd_rdy(rd_rdy),
  .src_addr(src_addr), .wr_stb(wr_stb), .wr_rdy(wr_rdy), .dst_addr(dst_addr),
  .wr_data(wr_data), .done(done)
);

// File: tb/sim_dreq_dma_front.sv
`timescale 1ns/1ps
module sim_dreq_dma_front;
  localparam int AW = 16, DW = 16, CW = 16;
  localparam int LAT = 7;  // WAIT_CYC(3) + 4

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_n = 1'b1, en_wr = 1'b0, en_wdata = 1'b0, cnt_load = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic rd_rdy = 1'b1, wr_rdy = 1'b1;
  logic bus_req, rd_stb, wr_stb, done;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] rd_data, wr_data;

  int checks = 0, fails = 0, xfers = 0, cyc = 0;
  logic [AW-1:0] exp_src, exp_dst, rd_seen;

  always #5 clk = ~clk;
  assign rd_data = src_addr ^ 16'h5A5A;

  dreq_dma_front u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .src_base(src_base), .dst_base(dst_base),
    .bus_req(bus_req), .rd_stb(rd_stb), .rd_rdy(rd_rdy), .src_addr(src_addr),
    .rd_data(rd_data), .wr_stb(wr_stb), .wr_rdy(wr_rdy), .dst_addr(dst_addr),
    .wr_data(wr_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Transfer monitor: R5 data and R7 addresses on every write handshake
  always @(negedge clk) if (rst_n) begin
    if (rd_stb && rd_rdy) rd_seen = src_addr;
    if (wr_stb && wr_rdy) begin
      chk(rd_seen == exp_src, "R7 source address", 32'(rd_seen), 32'(exp_src));
      chk(dst_addr == exp_dst, "R7 destination address", 32'(dst_addr), 32'(exp_dst));
      chk(wr_data == (rd_seen ^ 16'h5A5A), "R5 write data", 32'(wr_data), 32'(rd_seen ^ 16'h5A5A));
      exp_src = exp_src + 1'b1;
      exp_dst = exp_dst + 1'b1;
      xfers++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic load(input logic [CW-1:0] n, input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    cnt_load = 1'b1; cnt_val = n; src_base = s; dst_base = d;
    exp_src = s; exp_dst = d;
    @(negedge clk);
    cnt_load = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en_wr = 1'b1; en_wdata = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (bus_req && n < 200) begin @(negedge clk); n++; end
  endtask

  // Drop the line; return edges until bus_req and until rd_stb
  task automatic drop_time(output int t_bus, output int t_rd);
    int n = 0;
    t_bus = -1; t_rd = -1;
    @(negedge clk);
    req_n = 1'b0;
    while (n < 40) begin
      @(negedge clk); n++;
      if (bus_req && t_bus < 0) t_bus = n;
      if (rd_stb) begin t_rd = n; break; end
    end
  endtask

  task automatic quiet_window(input string req, input int len);
    bit seen = 1'b0;
    for (int i = 0; i < len; i++) begin @(negedge clk); if (bus_req) seen = 1'b1; end
    chk(!seen, req, 32'(seen), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!bus_req && !rd_stb && !wr_stb && !done, "R1 reset outputs",
        {28'd0, bus_req, rd_stb, wr_stb, done}, 32'd0);
  endtask

  task automatic t_disabled();
    load(16'd3, 16'h0100, 16'h0200);
    @(negedge clk); req_n = 1'b0;
    quiet_window("R2 no transfer while disabled", 15);
    req_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_latency_and_held_low();
    int tb, tr;
    set_en(1'b1);
    repeat (3) @(negedge clk);
    drop_time(tb, tr);
    chk(tb == 4, "R4 bus request rise", 32'(tb), 32'd4);
    chk(tr == LAT, "R3 R11 read strobe latency", 32'(tr), 32'(LAT));
    wait_idle();
    req_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(xfers == 1, "R5 one transfer per request", 32'(xfers), 32'd1);
    // second request held low past the end of the write
    drop_time(tb, tr);
    chk(tr == LAT, "R3 second latency", 32'(tr), 32'(LAT));
    wait_idle();
    @(negedge clk);
    chk(!bus_req, "R4 bus released after write", 32'(bus_req), 32'd0);
    quiet_window("R8 held-low line starts nothing", 20);
    chk(xfers == 2, "R8 transfer count while held low", 32'(xfers), 32'd2);
    req_n = 1'b1;
    repeat (5) @(negedge clk);
    drop_time(tb, tr);
    chk(tr == LAT, "R8 re-armed after high level", 32'(tr), 32'(LAT));
    wait_idle();
    @(negedge clk);
    chk(done, "R10 done after last transfer", 32'(done), 32'd1);
    req_n = 1'b1;
    repeat (4) @(negedge clk);
    req_n = 1'b0;
    quiet_window("R10 requests ignored after done", 20);
    chk(xfers == 3, "R10 total transfers", 32'(xfers), 32'd3);
    req_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_backpressure_rearm();
    int tb, tr;
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    bit held;
    load(16'd2, 16'h0300, 16'h0400);
    @(negedge clk);
    chk(!done, "R10 done cleared by load", 32'(done), 32'd0);
    set_en(1'b1);
    repeat (3) @(negedge clk);
    rd_rdy = 1'b0; wr_rdy = 1'b0;
    drop_time(tb, tr);
    chk(tr == LAT, "R3 latency with stall pending", 32'(tr), 32'(LAT));
    a0 = src_addr; held = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!rd_stb || src_addr != a0) held = 1'b0;
    end
    chk(held, "R6 read strobe held", 32'(held), 32'd1);
    rd_rdy = 1'b1;
    req_n = 1'b1;   // high level seen during the transfer
    @(negedge clk);
    chk(wr_stb && !rd_stb, "R5 write follows read", {30'd0, wr_stb, rd_stb}, 32'd2);
    d0 = wr_data; a0 = dst_addr; held = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!wr_stb || wr_data != d0 || dst_addr != a0) held = 1'b0;
    end
    chk(held, "R6 write strobe held", 32'(held), 32'd1);
    wr_rdy = 1'b1;
    @(negedge clk);
    chk(!bus_req, "R4 bus released", 32'(bus_req), 32'd0);
    drop_time(tb, tr);
    chk(tr == LAT, "R9 immediate re-arm latency", 32'(tr), 32'(LAT));
    wait_idle();
    @(negedge clk);
    chk(done && xfers == 5, "R10 done after second load", {31'd0, done} + 32'(xfers), 32'd6);
    req_n = 1'b1;
  endtask

  initial begin
    exp_src = '0; exp_dst = '0; rd_seen = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_disabled();
    t_latency_and_held_low();
    t_backpressure_rearm();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule